// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an external DDR1 or DDR2 device from power-up into a usable state on behalf of a memory controller. A single start pulse launches a fixed walk of SDRAM commands: precharge-all, auto-refresh, and the mode-register and extended-mode-register loads. Each command is shown to the controller as a one-hot code, paired with the register value it should drive onto the address bus. The controller executes each command at its own pace and returns an acknowledge. After that acknowledge the sequencer moves on to the next step.

Two straps are sampled when the start pulse is accepted. One picks the DDR1 or the DDR2 program. The other tells the block whether the reference clock runs at 40 MHz or 25 MHz, and that choice sets the refresh interval.

Before the first command the block presents these values:
- a maximal bus timeout;
- on DDR2 only, the DDR2 configuration word.

Once the last command is acknowledged it presents these values, then raises `initDone`:
- the refresh-control word;
- the two initial DQS tap settings;
- the read-cycle mask.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `cmdOut`, `modeVal`, `initDone`, `busy`, `busTimeout`, `ddr2Cfg`, `refreshWord`, `dqsTap0`, `dqsTap1` and `rdCycleMask` are all zero.
- R2: `cmdOut` is one-hot or zero, with this encoding: bit 0 is a mode-register load, bit 1 an extended-mode load, bit 2 auto-refresh, bit 3 precharge-all, bit 4 an EMR2 load and bit 5 an EMR3 load.
- R3: With `memIsDdr2`=1 the sequence of commands and values is as follows:
  - precharge-all;
  - EMR2 load with value 0;
  - EMR3 load with value 0;
  - extended-mode load with 0x000;
  - mode load with 0x100;
  - precharge-all;
  - auto-refresh, issued twice;
  - mode load with 0xA33;
  - extended-mode load with 0x382;
  - extended-mode load with 0x402.
- R4: With `memIsDdr2`=0 the sequence is: precharge-all; mode load with 0x133; extended-mode load with 0x002; precharge-all; mode load with 0x033.
- R5: For every load command, `modeVal` already holds the command's value one cycle before `cmdOut` rises, and it stays stable until the acknowledge.
- R6: A command stays on `cmdOut` until a cycle in which `cmdAck` is high. `cmdOut` reads zero in the cycle after that.
- R7: Before the first command, `busTimeout` reads 0xFFFFF. `ddr2Cfg` reads 0xA59 on DDR2 and zero on DDR1. The 0xA59 word packs write latency 2 in bits 13:10, the ODT enable in bit 9, tFAW 22 in bits 7:2 and the enable in bit 0.
- R8: At completion, `refreshWord` has bit 14 set and carries the interval in bits 9:0. The interval is 624 (0x4270) when `refClk40` was set at start, and 390 (0x4186) otherwise.
- R9: `dqsTap0`=0x08, `dqsTap1`=0x09 and `rdCycleMask`=0xFF appear together with `initDone`. All three stay zero while the commands run.
- R10: A start pulse that arrives while `busy` is high is ignored, and strap changes after the start is accepted have no effect on the run.
- R11: `initDone` stays high until the next start. A start accepted while done clears `initDone` and every output word in the following cycle, then runs a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start pulse |
| memIsDdr2 | input | 1 | Strap: 1 selects the DDR2 program |
| refClk40 | input | 1 | Strap: 1 means a 40 MHz reference clock |
| cmdAck | input | 1 | Controller accepted the current command |
| cmdOut | output | 6 | One-hot command code |
| modeVal | output | 13 | Value for the register being loaded |
| busTimeout | output | 20 | Bus timeout limit |
| ddr2Cfg | output | 16 | DDR2 configuration word |
| refreshWord | output | 16 | Refresh-control word |
| dqsTap0 | output | 6 | Initial DQS tap, lane 0 |
| dqsTap1 | output | 6 | Initial DQS tap, lane 1 |
| rdCycleMask | output | 8 | Read-cycle mask |
| busy | output | 1 | Sequence in progress |
| initDone | output | 1 | Sequence complete |

## Verification
When a start is accepted on edge E0:
- the configuration words settle after E1;
- the first value settles after E2;
- the first command rises after E3.

After an acknowledge sampled on edge Ek:
- `cmdOut` is zero after Ek;
- the next value is loaded on Ek+1;
- the next command rises after Ek+2.

The last acknowledge raises `initDone` and the final words two edges later.

The bench drives its inputs and samples the outputs on the falling edge. It treats the first nonzero `cmdOut` sample as the pulse start and compares `modeVal` from the sample before with the value seen then. It checks for zero on the sample that follows its own acknowledge, and reads the completion words on the first sample with `initDone` high.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int CMD_W  = 6;
  localparam int VAL_W  = 13;
  localparam int STEP_W = 4;

  localparam logic [CMD_W-1:0] CMD_NONE   = 6'h00;
  localparam logic [CMD_W-1:0] CMD_MRS    = 6'h01;
  localparam logic [CMD_W-1:0] CMD_EMRS   = 6'h02;
  localparam logic [CMD_W-1:0] CMD_AREF   = 6'h04;
  localparam logic [CMD_W-1:0] CMD_PREALL = 6'h08;
  localparam logic [CMD_W-1:0] CMD_EMR2   = 6'h10;
  localparam logic [CMD_W-1:0] CMD_EMR3   = 6'h20;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             hasVal;
    logic [VAL_W-1:0] val;
  } step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             clrAll;
    logic             loadCfg;
    logic             loadVal;
    logic             setCmd;
    logic             clrCmd;
    logic             loadFinal;
    logic             isDdr2;
    logic             is40;
    logic [CMD_W-1:0] cmdCode;
    logic [VAL_W-1:0] valData;
  } strobe_t;

  function automatic step_t mkStep(logic [CMD_W-1:0] c, logic h, int v);
    step_t s;
    s.cmd    = c;
    s.hasVal = h;
    s.val    = VAL_W'(v);
    return s;
  endfunction

  // fixed command program per memory type
  function automatic step_t stepOf(logic isDdr2, logic [STEP_W-1:0] idx);
    step_t s;
    s = mkStep(CMD_NONE, 1'b0, 0);
    if (isDdr2) begin
      case (idx)
        4'd0:  s = mkStep(CMD_PREALL, 1'b0, 0);
        4'd1:  s = mkStep(CMD_EMR2,   1'b1, 'h000);
        4'd2:  s = mkStep(CMD_EMR3,   1'b1, 'h000);
        4'd3:  s = mkStep(CMD_EMRS,   1'b1, 'h000);
        4'd4:  s = mkStep(CMD_MRS,    1'b1, 'h100);
        4'd5:  s = mkStep(CMD_PREALL, 1'b0, 0);
        4'd6:  s = mkStep(CMD_AREF,   1'b0, 0);
        4'd7:  s = mkStep(CMD_AREF,   1'b0, 0);
        4'd8:  s = mkStep(CMD_MRS,    1'b1, 'hA33);
        4'd9:  s = mkStep(CMD_EMRS,   1'b1, 'h382);
        4'd10: s = mkStep(CMD_EMRS,   1'b1, 'h402);
        default: s = mkStep(CMD_NONE, 1'b0, 0);
      endcase
    end else begin
      case (idx)
        4'd0:  s = mkStep(CMD_PREALL, 1'b0, 0);
        4'd1:  s = mkStep(CMD_MRS,    1'b1, 'h133);
        4'd2:  s = mkStep(CMD_EMRS,   1'b1, 'h002);
        4'd3:  s = mkStep(CMD_PREALL, 1'b0, 0);
        4'd4:  s = mkStep(CMD_MRS,    1'b1, 'h033);
        default: s = mkStep(CMD_NONE, 1'b0, 0);
      endcase
    end
    return s;
  endfunction

  function automatic logic [STEP_W-1:0] lastStep(logic isDdr2);
    return isDdr2 ? STEP_W'(10) : STEP_W'(4);
  endfunction

endpackage

// File: rtl/dis_ctrl.sv
module dis_ctrl
  import ddr_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    memIsDdr2,
  input  logic    refClk40,
  input  logic    cmdAck,
  output strobe_t stb,
  output logic    busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_CFG, S_LOAD, S_ARM, S_ISSUE, S_FINISH, S_DONE
  } state_e;

  state_e            state, stateNxt;
  logic [STEP_W-1:0] stepIdx, stepNxt;
  logic              selDdr2, sel40;
  logic              latchStraps;
  step_t             curStep;

  assign curStep = stepOf(selDdr2, stepIdx);
  assign busy    = (state != S_IDLE) && (state != S_DONE);

  always_comb begin
    stateNxt    = state;
    stepNxt     = stepIdx;
    latchStraps = 1'b0;
    stb         = '0;
    stb.isDdr2  = selDdr2;
    stb.is40    = sel40;
    stb.cmdCode = curStep.cmd;
    stb.valData = curStep.val;
    case (state)
      S_IDLE, S_DONE: begin
        if (startReq) begin
          stb.clrAll  = 1'b1;
          latchStraps = 1'b1;
          stepNxt     = '0;
          stateNxt    = S_CFG;
        end
      end
      S_CFG: begin
        stb.loadCfg = 1'b1;
        stateNxt    = S_LOAD;
      end
      S_LOAD: begin
        stb.loadVal = curStep.hasVal;
        stateNxt    = S_ARM;
      end
      S_ARM: begin
        stb.setCmd = 1'b1;
        stateNxt   = S_ISSUE;
      end
      S_ISSUE: begin
        if (cmdAck) begin
          stb.clrCmd = 1'b1;
          if (stepIdx == lastStep(selDdr2)) begin
            stateNxt = S_FINISH;
          end else begin
            stepNxt  = stepIdx + STEP_W'(1);
            stateNxt = S_LOAD;
          end
        end
      end
      S_FINISH: begin
        stb.loadFinal = 1'b1;
        stateNxt      = S_DONE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      selDdr2 <= 1'b0;
      sel40   <= 1'b0;
    end else begin
      state   <= stateNxt;
      stepIdx <= stepNxt;
      if (latchStraps) begin
        selDdr2 <= memIsDdr2;
        sel40   <= refClk40;
      end
    end
  end

  // R10: a start seen mid-run never restarts the program
  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (state != S_CFG));

  // R10: straps are frozen for the whole run
  a_r10_straps_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != S_CFG) |-> ($stable(selDdr2) && $stable(sel40)));

  // R3 R4: the step index never runs past the program end
  a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepIdx <= lastStep(selDdr2)));

endmodule

// File: rtl/dis_datapath.sv
module dis_datapath
  import ddr_init_pkg::*;
#(
  parameter int TO_W       = 20,
  parameter int CFG_W      = 16,
  parameter int REF_W      = 16,
  parameter int TAP_W      = 6,
  parameter int MASK_W     = 8,
  parameter int REF_INT_25 = 390,
  parameter int REF_INT_40 = 624,
  parameter int TAP0_INIT  = 8,
  parameter int TAP1_INIT  = 9,
  parameter int WR_LAT     = 2,
  parameter int TFAW_CYC   = 22
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [VAL_W-1:0]  modeVal,
  output logic [TO_W-1:0]   busTimeout,
  output logic [CFG_W-1:0]  ddr2Cfg,
  output logic [REF_W-1:0]  refreshWord,
  output logic [TAP_W-1:0]  dqsTap0,
  output logic [TAP_W-1:0]  dqsTap1,
  output logic [MASK_W-1:0] rdCycleMask,
  output logic              initDone
);

  localparam logic [TO_W-1:0]  TIMEOUT_MAX = '1;
  localparam logic [CFG_W-1:0] CFG_WORD    =
    CFG_W'(WR_LAT * 1024 + 512 + TFAW_CYC * 4 + 1);
  localparam int               REF_EN      = 1 << 14;
  localparam logic [REF_W-1:0] REF_WORD_25 = REF_W'(REF_EN + REF_INT_25);
  localparam logic [REF_W-1:0] REF_WORD_40 = REF_W'(REF_EN + REF_INT_40);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut      <= '0;
      modeVal     <= '0;
      busTimeout  <= '0;
      ddr2Cfg     <= '0;
      refreshWord <= '0;
      dqsTap0     <= '0;
      dqsTap1     <= '0;
      rdCycleMask <= '0;
      initDone    <= 1'b0;
    end else if (stb.clrAll) begin
      cmdOut      <= '0;
      modeVal     <= '0;
      busTimeout  <= '0;
      ddr2Cfg     <= '0;
      refreshWord <= '0;
      dqsTap0     <= '0;
      dqsTap1     <= '0;
      rdCycleMask <= '0;
      initDone    <= 1'b0;
    end else begin
      if (stb.loadCfg) begin
        busTimeout <= TIMEOUT_MAX;
        ddr2Cfg    <= stb.isDdr2 ? CFG_WORD : '0;
      end
      if (stb.loadVal) modeVal <= stb.valData;
      if (stb.setCmd) cmdOut <= stb.cmdCode;
      else if (stb.clrCmd) cmdOut <= '0;
      if (stb.loadFinal) begin
        refreshWord <= stb.is40 ? REF_WORD_40 : REF_WORD_25;
        dqsTap0     <= TAP_W'(TAP0_INIT);
        dqsTap1     <= TAP_W'(TAP1_INIT);
        rdCycleMask <= '1;
        initDone    <= 1'b1;
      end
    end
  end

  // R2: never more than one command bit
  a_r2_cmd_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut));

  // R5: the value does not move while a command is out
  a_r5_val_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != '0) |-> $stable(modeVal));

  // R9: no final word before completion
  a_r9_final_late: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone) |-> (dqsTap0 == '0 && dqsTap1 == '0 && rdCycleMask == '0));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int TO_W       = 20,
  parameter int CFG_W      = 16,
  parameter int REF_W      = 16,
  parameter int TAP_W      = 6,
  parameter int MASK_W     = 8,
  parameter int REF_INT_25 = 390,
  parameter int REF_INT_40 = 624,
  parameter int TAP0_INIT  = 8,
  parameter int TAP1_INIT  = 9,
  parameter int WR_LAT     = 2,
  parameter int TFAW_CYC   = 22
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              memIsDdr2,
  input  logic              refClk40,
  input  logic              cmdAck,
  output logic [5:0]        cmdOut,
  output logic [12:0]       modeVal,
  output logic [TO_W-1:0]   busTimeout,
  output logic [CFG_W-1:0]  ddr2Cfg,
  output logic [REF_W-1:0]  refreshWord,
  output logic [TAP_W-1:0]  dqsTap0,
  output logic [TAP_W-1:0]  dqsTap1,
  output logic [MASK_W-1:0] rdCycleMask,
  output logic              busy,
  output logic              initDone
);

  strobe_t stb;

  dis_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .memIsDdr2 (memIsDdr2),
    .refClk40  (refClk40),
    .cmdAck    (cmdAck),
    .stb       (stb),
    .busy      (busy)
  );

  dis_datapath #(
    .TO_W(TO_W), .CFG_W(CFG_W), .REF_W(REF_W), .TAP_W(TAP_W),
    .MASK_W(MASK_W), .REF_INT_25(REF_INT_25), .REF_INT_40(REF_INT_40),
    .TAP0_INIT(TAP0_INIT), .TAP1_INIT(TAP1_INIT),
    .WR_LAT(WR_LAT), .TFAW_CYC(TFAW_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cmdOut      (cmdOut),
    .modeVal     (modeVal),
    .busTimeout  (busTimeout),
    .ddr2Cfg     (ddr2Cfg),
    .refreshWord (refreshWord),
    .dqsTap0     (dqsTap0),
    .dqsTap1     (dqsTap1),
    .rdCycleMask (rdCycleMask),
    .initDone    (initDone)
  );

  // R6: held until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != '0 && !cmdAck) |=> (cmdOut == $past(cmdOut)));

  // R6: released right after acknowledge
  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != '0 && cmdAck) |=> (cmdOut == '0));

  // R11: done is sticky until a new start
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && !startReq) |=> initDone);

  // R8: completion carries an enabled refresh word
  a_r8_refresh_enabled: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> refreshWord[14]);

  // R7: a command only appears once the timeout is programmed
  a_r7_timeout_first: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != '0) |-> (busTimeout == '1));

endmodule

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        memIsDdr2 = 1'b0;
  logic        refClk40 = 1'b0;
  logic        cmdAck = 1'b0;
  logic [5:0]  cmdOut;
  logic [12:0] modeVal;
  logic [19:0] busTimeout;
  logic [15:0] ddr2Cfg;
  logic [15:0] refreshWord;
  logic [5:0]  dqsTap0;
  logic [5:0]  dqsTap1;
  logic [7:0]  rdCycleMask;
  logic        busy;
  logic        initDone;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  ddr_init_seq u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memIsDdr2(memIsDdr2),
    .refClk40(refClk40), .cmdAck(cmdAck), .cmdOut(cmdOut), .modeVal(modeVal),
    .busTimeout(busTimeout), .ddr2Cfg(ddr2Cfg), .refreshWord(refreshWord),
    .dqsTap0(dqsTap0), .dqsTap1(dqsTap1), .rdCycleMask(rdCycleMask),
    .busy(busy), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected program, written from R3 and R4
  function automatic int expLen(bit d2);
    return d2 ? 11 : 5;
  endfunction

  function automatic int expCmd(bit d2, int i);
    int d2Cmd[11] = '{8, 16, 32, 2, 1, 8, 4, 4, 1, 2, 2};
    int d1Cmd[5]  = '{8, 1, 2, 8, 1};
    return d2 ? d2Cmd[i] : d1Cmd[i];
  endfunction

  function automatic int expVal(bit d2, int i);
    int d2Val[11] = '{0, 'h000, 'h000, 'h000, 'h100, 0, 0, 0, 'hA33, 'h382, 'h402};
    int d1Val[5]  = '{0, 'h133, 'h002, 0, 'h033};
    return d2 ? d2Val[i] : d1Val[i];
  endfunction

  function automatic bit isLoad(int c);
    return (c == 1) || (c == 2) || (c == 16) || (c == 32);
  endfunction

  task automatic runOnce(input bit d2, input bit c40, input int maxDelay, input bit poke);
    int idx = 0;
    int cyc = 0;
    int waitCnt = 0;
    int delay = 0;
    int prevCmd = 0;
    int prevVal = 0;
    int heldVal = 0;
    bit ackSent = 0;
    memIsDdr2 = d2;
    refClk40  = c40;
    startReq  = 1'b1;
    @(negedge clk);
    startReq  = 1'b0;
    // flipped straps must not matter (R10)
    memIsDdr2 = ~d2;
    refClk40  = ~c40;
    check(initDone == 1'b0 && busy == 1'b1, "R11 restart clears done", int'(initDone), 0);
    check(dqsTap0 == 0 && refreshWord == 0, "R11 restart clears words", int'(refreshWord), 0);
    while (!initDone && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (startReq) startReq = 1'b0;
      if (ackSent) begin
        check(cmdOut == 0, "R6 drop after ack", int'(cmdOut), 0);
        cmdAck  = 1'b0;
        ackSent = 0;
      end else if (cmdOut != 0) begin
        if (prevCmd == 0) begin
          check($countones(cmdOut) == 1, "R2 one-hot", int'(cmdOut), 1);
          if (idx < expLen(d2)) begin
            check(int'(cmdOut) == expCmd(d2, idx), d2 ? "R3 command" : "R4 command",
                  int'(cmdOut), expCmd(d2, idx));
            if (isLoad(expCmd(d2, idx))) begin
              check(int'(modeVal) == expVal(d2, idx), d2 ? "R3 value" : "R4 value",
                    int'(modeVal), expVal(d2, idx));
              check(prevVal == int'(modeVal), "R5 value set before pulse",
                    prevVal, int'(modeVal));
            end
          end else begin
            check(0, "R3 R4 extra command", int'(cmdOut), 0);
          end
          if (idx == 0) begin
            check(busTimeout == 20'hFFFFF, "R7 timeout", int'(busTimeout), 'hFFFFF);
            check(int'(ddr2Cfg) == (d2 ? 'hA59 : 0), "R7 ddr2 cfg", int'(ddr2Cfg),
                  d2 ? 'hA59 : 0);
          end
          check(dqsTap0 == 0 && rdCycleMask == 0 && !initDone, "R9 nothing early",
                int'(rdCycleMask), 0);
          heldVal = int'(modeVal);
          idx++;
          waitCnt = 0;
          delay = $urandom_range(maxDelay, 0);
          if (poke && idx == 3) begin
            startReq  = 1'b1;
            memIsDdr2 = ~d2;
            refClk40  = ~c40;
          end
        end else begin
          check(int'(modeVal) == heldVal, "R5 value stable", int'(modeVal), heldVal);
        end
        if (waitCnt >= delay) begin
          cmdAck  = 1'b1;
          ackSent = 1;
        end else begin
          waitCnt++;
        end
      end
      prevCmd = int'(cmdOut);
      prevVal = int'(modeVal);
    end
    cmdAck   = 1'b0;
    startReq = 1'b0;
    check(cyc < 3000, "watchdog", cyc, 3000);
    check(idx == expLen(d2), d2 ? "R3 length" : "R4 length", idx, expLen(d2));
    check(int'(refreshWord) == (c40 ? 'h4270 : 'h4186), "R8 refresh word",
          int'(refreshWord), c40 ? 'h4270 : 'h4186);
    check(dqsTap0 == 6'h08 && dqsTap1 == 6'h09, "R9 taps", int'({dqsTap0, dqsTap1}), 'h209);
    check(rdCycleMask == 8'hFF, "R9 mask", int'(rdCycleMask), 'hFF);
    check(int'(ddr2Cfg) == (d2 ? 'hA59 : 0), "R7 cfg kept", int'(ddr2Cfg), d2 ? 'hA59 : 0);
    for (int k = 0; k < 4; k++) @(negedge clk);
    check(initDone == 1'b1 && busy == 1'b0 && cmdOut == 0, "R11 done sticky",
          int'(initDone), 1);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(cmdOut == 0 && modeVal == 0 && !initDone && !busy, "R1 reset ctrl", int'(cmdOut), 0);
    check(busTimeout == 0 && ddr2Cfg == 0 && refreshWord == 0, "R1 reset words",
          int'(busTimeout), 0);
    check(dqsTap0 == 0 && dqsTap1 == 0 && rdCycleMask == 0, "R1 reset taps",
          int'(rdCycleMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed: each strap pair, immediate ack, start poked mid-run (R10)
    runOnce(1'b1, 1'b1, 0, 1'b1);
    runOnce(1'b1, 1'b0, 0, 1'b1);
    runOnce(1'b0, 1'b1, 0, 1'b1);
    runOnce(1'b0, 1'b0, 0, 1'b1);
    // random straps and ack delays
    for (int r = 0; r < 24; r++) begin
      runOnce(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 4,
              1'($urandom_range(1, 0)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule